// File: doc/BRIEF.md
# Dual-Width Integer Add/Shift Unit

This is a combinational integer unit for a core whose registers run either 32 or 64 bits wide. The active width is picked at run time from three status bits. The privilege bit chooses which of the two width-enable bits applies. The unit adds, subtracts and adds an immediate. It also performs logical left, logical right and arithmetic right shifts, with the amount taken from a register or from the immediate. A second group of word operations leaves a 32-bit result inside a 64-bit register.

Every result is sign-extended from the active width. When the active width is 32, the word operations are refused, and so is an immediate shift whose amount reaches 32 or more. A refused operation raises an illegal-instruction flag and drives a zero result. The surrounding pipeline takes the trap from that flag.

Top module: `dw_addshift`

## Requirements
- R1: The active width is 64 when status[0] (privileged) is 1 and status[1] is 1, or when status[0] is 0 and status[2] is 1; in every other case it is 32.
- R2: Add (select 0), subtract (1) and add-immediate (2) wrap at the active width. The result is sign-extended from bit 31 in 32-bit mode and is the full 64-bit value in 64-bit mode.
- R3: The 12-bit immediate is treated as signed and is sign-extended to 64 bits before use.
- R4: The register-amount shifts are left (3), logical right (4) and arithmetic right (5). Each uses the low 6 bits of the second operand in 64-bit mode and the low 5 bits in 32-bit mode.
- R5: In 32-bit mode, a logical right shift works on the zero-extended low 32 bits of the first operand, and its result is sign-extended from bit 31.
- R6: Arithmetic right shifts work on the full 64-bit first operand. The shifted value is then sign-extended from the active width.
- R7: The immediate-amount shifts are left (6), logical right (7) and arithmetic right (8), with the amount in immediate bits [5:0]. In 32-bit mode, if immediate bit 5 is 1, the illegal flag goes high and the result is zero.
- R8: The word selects are 9 addw, 10 subw, 11 addiw, 12 sllw, 13 srlw, 14 sraw, 15 slliw, 16 srliw and 17 sraiw. In 32-bit mode each of them raises the illegal flag and gives a zero result.
- R9: In 64-bit mode, word selects sign-extend the low 32 bits of their result. Their shift amount is 5 bits: operand bits [4:0] or immediate bits [4:0]. Logical right word shifts zero-extend the low 32 bits of the operand first.
- R10: Select values 18 to 31 raise the illegal flag and give a zero result. Legal operations leave the flag low.
- R11: The unit holds no state. Its outputs follow its inputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation select (codes in R2, R4, R7, R8) |
| status | input | 3 | Bit 0 privileged, bit 1 privileged-64, bit 2 user-64 |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand or shift amount |
| imm | input | 12 | Signed immediate or immediate shift amount |
| result | output | 64 | Sign-extended result, zero when illegal |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The bound checker watches the trap logic at all times. It confirms that a raised flag always comes with a zero result, and that 32-bit mode never lets a word select or an oversized immediate shift through. It also confirms that a narrow or word result always carries its bit 31 into the upper half, and that undefined selects always trap. Only the bench's vectors can show the arithmetic values. These include the choice of mask width for the shift count, zero-extension on a narrow logical right shift, and arithmetic shifts drawing on the upper half of the operand. The same holds for the immediate sign extension and the corner cases of width selection.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

    localparam int XW     = 64;
    localparam int NW     = 32;
    localparam int IMM_W  = 12;
    localparam int SEL_W  = 5;
    localparam int ST_W   = 3;
    localparam int XSH_W  = $clog2(XW);
    localparam int NSH_W  = $clog2(NW);

    // status bit positions
    localparam int ST_PRIV  = 0;
    localparam int ST_PRIVW = 1;
    localparam int ST_USRW  = 2;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_ADDI  = 5'd2,
        OP_SLL   = 5'd3,
        OP_SRL   = 5'd4,
        OP_SRA   = 5'd5,
        OP_SLLI  = 5'd6,
        OP_SRLI  = 5'd7,
        OP_SRAI  = 5'd8,
        OP_ADDW  = 5'd9,
        OP_SUBW  = 5'd10,
        OP_ADDIW = 5'd11,
        OP_SLLW  = 5'd12,
        OP_SRLW  = 5'd13,
        OP_SRAW  = 5'd14,
        OP_SLLIW = 5'd15,
        OP_SRLIW = 5'd16,
        OP_SRAIW = 5'd17
    } op_e;

    typedef enum logic [2:0] {
        K_ADD  = 3'd0,
        K_SUB  = 3'd1,
        K_SHL  = 3'd2,
        K_SHRL = 3'd3,
        K_SHRA = 3'd4
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  use_imm;    // second source is the immediate
        logic  word;       // word form: 32-bit result, 64-bit mode only
        logic  imm_shift;  // non-word immediate shift (bit 5 check)
        logic  known;      // select is defined
    } ctl_t;

    function automatic logic [XW-1:0] sext_narrow(input logic [XW-1:0] v);
        return {{(XW-NW){v[NW-1]}}, v[NW-1:0]};
    endfunction

    function automatic logic [XW-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XW-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/dw_width_sel.sv
module dw_width_sel
    import dwalu_pkg::*;
(
    input  logic [ST_W-1:0] status,
    output logic            wide
);

    always_comb begin
        if (status[ST_PRIV])
            wide = status[ST_PRIVW];
        else
            wide = status[ST_USRW];
    end

endmodule

// File: rtl/dw_decode.sv
module dw_decode
    import dwalu_pkg::*;
(
    input  logic [SEL_W-1:0] op_sel,
    output ctl_t             ctl
);

    always_comb begin
        ctl = '{kind: K_ADD, use_imm: 1'b0, word: 1'b0, imm_shift: 1'b0, known: 1'b1};
        case (op_sel)
            OP_ADD:   ctl.kind = K_ADD;
            OP_SUB:   ctl.kind = K_SUB;
            OP_ADDI:  begin ctl.kind = K_ADD;  ctl.use_imm = 1'b1; end
            OP_SLL:   ctl.kind = K_SHL;
            OP_SRL:   ctl.kind = K_SHRL;
            OP_SRA:   ctl.kind = K_SHRA;
            OP_SLLI:  begin ctl.kind = K_SHL;  ctl.use_imm = 1'b1; ctl.imm_shift = 1'b1; end
            OP_SRLI:  begin ctl.kind = K_SHRL; ctl.use_imm = 1'b1; ctl.imm_shift = 1'b1; end
            OP_SRAI:  begin ctl.kind = K_SHRA; ctl.use_imm = 1'b1; ctl.imm_shift = 1'b1; end
            OP_ADDW:  begin ctl.kind = K_ADD;  ctl.word = 1'b1; end
            OP_SUBW:  begin ctl.kind = K_SUB;  ctl.word = 1'b1; end
            OP_ADDIW: begin ctl.kind = K_ADD;  ctl.word = 1'b1; ctl.use_imm = 1'b1; end
            OP_SLLW:  begin ctl.kind = K_SHL;  ctl.word = 1'b1; end
            OP_SRLW:  begin ctl.kind = K_SHRL; ctl.word = 1'b1; end
            OP_SRAW:  begin ctl.kind = K_SHRA; ctl.word = 1'b1; end
            OP_SLLIW: begin ctl.kind = K_SHL;  ctl.word = 1'b1; ctl.use_imm = 1'b1; end
            OP_SRLIW: begin ctl.kind = K_SHRL; ctl.word = 1'b1; ctl.use_imm = 1'b1; end
            OP_SRAIW: begin ctl.kind = K_SHRA; ctl.word = 1'b1; ctl.use_imm = 1'b1; end
            default:  ctl.known = 1'b0;
        endcase
    end

endmodule

// File: rtl/dw_shifter.sv
module dw_shifter #(
    parameter int W  = 64,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  dout
);

    logic [W-1:0] din_rev;
    logic [W-1:0] stg [SW+1];
    logic [W-1:0] last_rev;
    logic         fill;

    // left shifts reuse the right-shift stages on bit-reversed data
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign din_rev[i]  = din[W-1-i];
        assign last_rev[i] = stg[SW][W-1-i];
    end

    assign fill   = arith & ~left & din[W-1];
    assign stg[0] = left ? din_rev : din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
    end

    assign dout = left ? last_rev : stg[SW];

endmodule

// File: rtl/dw_addshift.sv
module dw_addshift
    import dwalu_pkg::*;
(
    input  logic [SEL_W-1:0] op_sel,
    input  logic [ST_W-1:0]  status,
    input  logic [XW-1:0]    src_a,
    input  logic [XW-1:0]    src_b,
    input  logic [IMM_W-1:0] imm,
    output logic [XW-1:0]    result,
    output logic             illegal
);

    logic          wide;
    ctl_t          ctl;
    logic          narrow;
    logic [XW-1:0] opnd_b;
    logic [XW-1:0] sum;
    logic [XSH_W-1:0] amt;
    logic [XW-1:0] sh_in;
    logic [XW-1:0] sh_out;
    logic [XW-1:0] raw;
    logic          trap;

    dw_width_sel u_width (
        .status (status),
        .wide   (wide)
    );

    dw_decode u_dec (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    assign narrow = ctl.word | ~wide;
    assign opnd_b = ctl.use_imm ? sext_imm(imm) : src_b;
    assign sum    = (ctl.kind == K_SUB) ? (src_a - opnd_b) : (src_a + opnd_b);

    // count: 6 bits at full width, 5 bits when the result is narrow
    assign amt = narrow ? XSH_W'(opnd_b[NSH_W-1:0]) : opnd_b[XSH_W-1:0];

    // narrow logical right shift starts from the zero-extended low half
    assign sh_in = (ctl.kind == K_SHRL && narrow) ? {{(XW-NW){1'b0}}, src_a[NW-1:0]} : src_a;

    dw_shifter #(.W(XW), .SW(XSH_W)) u_shift (
        .din   (sh_in),
        .amt   (amt),
        .left  (ctl.kind == K_SHL),
        .arith (ctl.kind == K_SHRA),
        .dout  (sh_out)
    );

    assign raw  = (ctl.kind == K_ADD || ctl.kind == K_SUB) ? sum : sh_out;
    assign trap = ~ctl.known
                | (ctl.word & ~wide)
                | (ctl.imm_shift & ~wide & imm[NSH_W]);

    always_comb begin
        if (trap)
            result = '0;
        else if (narrow)
            result = sext_narrow(raw);
        else
            result = raw;
    end

    assign illegal = trap;

endmodule

// File: rtl/dw_addshift_chk.sv
module dw_addshift_chk
    import dwalu_pkg::*;
(
    input logic [SEL_W-1:0] op_sel,
    input logic [ST_W-1:0]  status,
    input logic             imm_b5,
    input logic [XW-1:0]    result,
    input logic             illegal
);

    logic wide_c;
    logic is_word;
    logic is_ishift;
    logic upper_ok;

    always_comb begin
        wide_c    = (status[ST_PRIV] && status[ST_PRIVW]) || (!status[ST_PRIV] && status[ST_USRW]);
        is_word   = (op_sel >= OP_ADDW) && (op_sel <= OP_SRAIW);
        is_ishift = (op_sel >= OP_SLLI) && (op_sel <= OP_SRAI);
        upper_ok  = (result[XW-1:NW] == {(XW-NW){result[NW-1]}});

        p_ill_zero_r10: assert (!illegal || result == '0)
            else $error("illegal flag with nonzero result");
        p_bad_sel_r10: assert (op_sel <= OP_SRAIW || illegal)
            else $error("undefined select did not trap");
        p_narrow_sext_r2: assert (wide_c || illegal || upper_ok)
            else $error("32-bit mode result not sign-extended");
        p_word_trap_r8: assert (!(is_word && !wide_c) || illegal)
            else $error("word select accepted in 32-bit mode");
        p_word_sext_r9: assert (!is_word || upper_ok)
            else $error("word result not sign-extended");
        p_imm_shift_trap_r7: assert (!(is_ishift && !wide_c && imm_b5) || illegal)
            else $error("oversized immediate shift accepted");
        p_legal_ok_r1: assert (op_sel > OP_SRAIW || (is_word && !wide_c)
                               || (is_ishift && !wide_c && imm_b5) || !illegal)
            else $error("legal operation trapped");
    end

endmodule

bind dw_addshift dw_addshift_chk u_chk (
    .op_sel  (op_sel),
    .status  (status),
    .imm_b5  (imm[5]),
    .result  (result),
    .illegal (illegal)
);

// File: tb/sim_dw_addshift.sv
module sim_dw_addshift;
    import dwalu_pkg::*;

    typedef struct packed {
        logic [4:0]  op;
        logic [2:0]  st;
        logic [63:0] a;
        logic [63:0] b;
        logic [11:0] im;
        logic [63:0] exp;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  3'b011, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 12'h000, 64'h8000_0000_0000_0000, 1'b0, 4'd2}, // R2
        '{5'd0,  3'b001, 64'h0000_0000_7FFF_FFFF, 64'd1, 12'h000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd2}, // R2
        '{5'd1,  3'b101, 64'd5, 64'd7, 12'h000, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 4'd1},                   // R1
        '{5'd2,  3'b100, 64'h10, 64'd0, 12'hFFF, 64'h0000_0000_0000_000F, 1'b0, 4'd3},                 // R3
        '{5'd2,  3'b011, 64'd0, 64'd0, 12'h800, 64'hFFFF_FFFF_FFFF_F800, 1'b0, 4'd3},                  // R3
        '{5'd0,  3'b010, 64'h0000_0001_0000_0000, 64'd0, 12'h000, 64'd0, 1'b0, 4'd1},                  // R1
        '{5'd3,  3'b011, 64'd1, 64'h47, 12'h000, 64'h80, 1'b0, 4'd4},                                  // R4
        '{5'd3,  3'b001, 64'd1, 64'h3F, 12'h000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd4},                 // R4
        '{5'd4,  3'b001, 64'hFFFF_FFFF_8000_0000, 64'd4, 12'h000, 64'h0000_0000_0800_0000, 1'b0, 4'd5}, // R5
        '{5'd4,  3'b001, 64'h0000_0000_8000_0000, 64'd0, 12'h000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd5}, // R5
        '{5'd4,  3'b011, 64'h8000_0000_0000_0000, 64'd63, 12'h000, 64'd1, 1'b0, 4'd4},                 // R4
        '{5'd5,  3'b011, 64'h8000_0000_0000_0000, 64'd4, 12'h000, 64'hF800_0000_0000_0000, 1'b0, 4'd6}, // R6
        '{5'd5,  3'b001, 64'h0000_0000_8000_0000, 64'd1, 12'h000, 64'h0000_0000_4000_0000, 1'b0, 4'd6}, // R6
        '{5'd5,  3'b001, 64'hFFFF_FFFF_8000_0000, 64'h21, 12'h000, 64'hFFFF_FFFF_C000_0000, 1'b0, 4'd6}, // R6
        '{5'd6,  3'b011, 64'd1, 64'd0, 12'h020, 64'h0000_0001_0000_0000, 1'b0, 4'd7},                  // R7
        '{5'd6,  3'b001, 64'd1, 64'd0, 12'h020, 64'd0, 1'b1, 4'd7},                                    // R7
        '{5'd8,  3'b001, 64'hFFFF_FFFF_8000_0000, 64'd0, 12'h004, 64'hFFFF_FFFF_F800_0000, 1'b0, 4'd7}, // R7
        '{5'd9,  3'b001, 64'd1, 64'd1, 12'h000, 64'd0, 1'b1, 4'd8},                                    // R8
        '{5'd16, 3'b000, 64'hFF, 64'd0, 12'h001, 64'd0, 1'b1, 4'd8},                                   // R8
        '{5'd9,  3'b011, 64'h0000_0000_7FFF_FFFF, 64'd1, 12'h000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd9}, // R9
        '{5'd10, 3'b100, 64'h0000_0001_0000_0000, 64'd1, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd9}, // R9
        '{5'd11, 3'b011, 64'h0000_0000_FFFF_FFFF, 64'd0, 12'h001, 64'd0, 1'b0, 4'd9},                  // R9
        '{5'd12, 3'b011, 64'd1, 64'h3F, 12'h000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd9},                 // R9
        '{5'd13, 3'b011, 64'hFFFF_FFFF_FFFF_FFFF, 64'h24, 12'h000, 64'h0000_0000_0FFF_FFFF, 1'b0, 4'd9}, // R9
        '{5'd14, 3'b011, 64'hFFFF_FFFF_8000_0000, 64'd8, 12'h000, 64'hFFFF_FFFF_FF80_0000, 1'b0, 4'd9}, // R9
        '{5'd15, 3'b011, 64'd3, 64'd0, 12'h03F, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'd9},                  // R9
        '{5'd17, 3'b100, 64'h0000_0000_8000_0000, 64'd0, 12'h004, 64'h0000_0000_0800_0000, 1'b0, 4'd9}, // R9
        '{5'd18, 3'b011, 64'd5, 64'd5, 12'h000, 64'd0, 1'b1, 4'd10},                                   // R10
        '{5'd31, 3'b001, 64'd5, 64'd5, 12'h000, 64'd0, 1'b1, 4'd10},                                   // R10
        '{5'd1,  3'b100, 64'd0, 64'd1, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd1},                  // R1
        '{5'd7,  3'b011, 64'hF000_0000_0000_0000, 64'd0, 12'hFFC, 64'h0000_0000_0000_000F, 1'b0, 4'd7}  // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_sel = '0;
    logic [2:0]  status = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [11:0] imm = '0;
    logic [63:0] result;
    logic        illegal;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dw_addshift u0 (
        .op_sel  (op_sel),
        .status  (status),
        .src_a   (src_a),
        .src_b   (src_b),
        .imm     (imm),
        .result  (result),
        .illegal (illegal)
    );

    task automatic check(input string tag, input logic [63:0] got_r, input logic got_i,
                         input logic [63:0] exp_r, input logic exp_i);
        n_chk++;
        if (got_r !== exp_r || got_i !== exp_i) begin
            n_err++;
            $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                     tag, got_r, got_i, exp_r, exp_i);
        end
    endtask

    initial begin
        // reset state: all inputs zero gives add 0+0 in 32-bit mode (R11)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset", result, illegal, 64'd0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel = VECS[i].op;
            status = VECS[i].st;
            src_a  = VECS[i].a;
            src_b  = VECS[i].b;
            imm    = VECS[i].im;
            #1;
            check($sformatf("R%0d vec%0d", VECS[i].req, i), result, illegal, VECS[i].exp, VECS[i].ill);
        end

        // R11: output follows inputs between clock edges
        @(posedge clk);
        #1;
        op_sel = 5'd0; status = 3'b011; src_a = 64'd5; src_b = 64'd6; imm = '0;
        #1;
        check("R11 same-cycle", result, illegal, 64'd11, 1'b0);
        src_b = 64'd7;
        #1;
        check("R11 follow", result, illegal, 64'd12, 1'b0);

        // R1: flipping privilege bit alone switches width for the same add
        src_a = 64'h0000_0000_7FFF_FFFF; src_b = 64'd1;
        status = 3'b110;  // user mode, user-64 set -> 64-bit
        #1;
        check("R1 user wide", result, illegal, 64'h0000_0000_8000_0000, 1'b0);
        status = 3'b111 ^ 3'b010;  // privileged, privileged-64 clear -> 32-bit
        #1;
        check("R1 priv narrow", result, illegal, 64'hFFFF_FFFF_8000_0000, 1'b0);

        // R7: 64-bit mode accepts immediate shift amount 63
        op_sel = 5'd6; status = 3'b011; src_a = 64'd1; imm = 12'h03F;
        #1;
        check("R7 slli 63", result, illegal, 64'h8000_0000_0000_0000, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule